// File: doc/BRIEF.md
# Static Memory Width-Adapting Access Splitter

This block sits between a 32-bit system bus port and a shared external static memory bus with four chip-select regions. One request may carry 8, 16 or 32 bits. The block looks up the target region's settings: memory width (8 or 16 bits), whether the device has byte-lane selects, and whether writes are allowed. It then turns the request into one or more memory-wide accesses. For each access it works out the word address, the active-low lane enables, the write data lanes and the chip select.

The block does not produce pin timing. Each sub-access is offered to a downstream timing engine through a level request (`mem_req`), and the engine ends it with a one-cycle `mem_done`. The block merges read bytes into a right-justified 32-bit result. It gives the system side one completion after the last sub-access. Two kinds of write are refused with an error and produce no external access: a write to a region with writes disabled, and a byte write to a 16-bit device that has no byte selects.

Top module: `xmem_splitter`

## Requirements
- R1: Byte address bits 27:26 select region n. While a sub-access is in flight, only `mem_cs_n[n]` is low. All chip selects are high whenever `mem_req` is low.
- R2: For an 8-bit region, the external address is byte-address bits 25:0. For a 16-bit region, it is byte-address bits 25:1, with bit 25 of the external address driven to zero. Each further sub-access of one request adds one to the external address.
- R3: Size code 0 is a byte, 1 is a halfword, and 2 or 3 is a word. A request no wider than the memory takes exactly one sub-access. A wider request takes size/width sub-accesses, and the least significant part goes first.
- R4: Lane enable bit i low means byte lane i is written, where lane 0 is `mem_wdata[7:0]`. An 8-bit region is always written with lane enables 2'b10. A 16-bit region with byte selects takes a byte write with 2'b10 when address bit 0 is 0 and 2'b01 when it is 1, and takes wider writes with 2'b00. Write data is right-justified in `req_wdata`. A byte is driven on both lanes, and 16-bit pieces are driven as they are.
- R5: Reads hold both lane enables low. Only the requested bytes are kept: for a byte read of a 16-bit region, the lane chosen by address bit 0. The response is right-justified and zero-filled. Writes and errors return zero data.
- R6: A 16-bit region without byte selects rejects a byte write with an error and no external access. Byte reads of such a region still work as full-word reads.
- R7: A write to a region whose write enable is low completes with an error and no external access. Reads of that region work normally.
- R8: Exactly one `rsp_valid` pulse, one cycle long, follows each accepted request, and it comes after the last sub-access ends. `req_ready` is high only when the block is idle, including after reset.
- R9: Address, lane enables, write data and chip selects stay stable while `mem_req` is high and `mem_done` has not arrived. Only one sub-access is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | System request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | 28 | Byte address, top two bits pick the region |
| req_wdata | input | 32 | Right-justified write data |
| cfg_wide | input | 4 | Per region: 1 = 16-bit memory, 0 = 8-bit |
| cfg_bsel | input | 4 | Per region: device has byte-lane selects |
| cfg_wen | input | 4 | Per region: writes allowed |
| rsp_valid | output | 1 | One-cycle completion |
| rsp_err | output | 1 | Completion is an error |
| rsp_rdata | output | 32 | Assembled read data |
| mem_req | output | 1 | Sub-access offered to timing engine |
| mem_write | output | 1 | Sub-access is a write |
| mem_cs_n | output | 4 | Active-low chip selects |
| mem_addr | output | 26 | External word address |
| mem_be_n | output | 2 | Active-low byte-lane enables |
| mem_wdata | output | 16 | Write data lanes |
| mem_rdata | input | 16 | Read data from timing engine |
| mem_done | input | 1 | Sub-access finished (one cycle) |

## Verification
The assertions assume three things about the inputs: requests are naturally aligned to their size, `mem_done` is pulsed only while `mem_req` is high, and the configuration of a region does not change while that region is being accessed. The stimulus respects all three. Every address it issues is aligned. The memory model raises `mem_done` for a single cycle, only while a sub-access is offered, and varies its delay from beat to beat. The region settings are rotated only between requests, so every region meets every kind of device.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  localparam int SYS_DW    = 32;
  localparam int MEM_DW    = 16;
  localparam int ADDR_W    = 28;
  localparam int NUM_CS    = 4;
  localparam int CS_W      = $clog2(NUM_CS);
  localparam int EXT_AW    = ADDR_W - CS_W;
  localparam int MAX_BEATS = SYS_DW / 8;
  localparam int BEAT_W    = $clog2(MAX_BEATS);

  typedef enum logic [1:0] {ST_IDLE, ST_BEAT, ST_RESP} xstate_e;

  typedef struct packed {
    logic wide;
    logic bsel;
    logic wen;
  } region_cfg_t;

  // bytes carried by a request size code
  function automatic logic [BEAT_W:0] size_bytes(logic [1:0] sz);
    case (sz)
      2'd0:    return (BEAT_W+1)'(1);
      2'd1:    return (BEAT_W+1)'(2);
      default: return (BEAT_W+1)'(4);
    endcase
  endfunction

  // number of memory-wide sub-accesses for one request
  function automatic logic [BEAT_W:0] beat_count(logic [1:0] sz, logic wide);
    logic [BEAT_W:0] nb;
    nb = size_bytes(sz);
    if (!wide) return nb;
    return (nb == (BEAT_W+1)'(4)) ? (BEAT_W+1)'(2) : (BEAT_W+1)'(1);
  endfunction

  // external word address of a given beat
  function automatic logic [EXT_AW-1:0] ext_addr(logic [EXT_AW-1:0] ba, logic wide,
                                                 logic [BEAT_W-1:0] beat);
    logic [EXT_AW-1:0] base;
    base = wide ? {1'b0, ba[EXT_AW-1:1]} : ba;
    return base + EXT_AW'(beat);
  endfunction

  // active-low lane enables
  function automatic logic [1:0] lane_en_n(logic wr, logic wide, logic [1:0] sz, logic a0);
    if (!wr)       return 2'b00;
    if (!wide)     return 2'b10;
    if (sz == 2'd0) return a0 ? 2'b01 : 2'b10;
    return 2'b00;
  endfunction

  // write data placed on the memory lanes for one beat
  function automatic logic [MEM_DW-1:0] beat_wdata(logic [SYS_DW-1:0] wd, logic wide,
                                                   logic [1:0] sz, logic [BEAT_W-1:0] beat);
    logic [7:0] b;
    if (!wide || sz == 2'd0) begin
      b = wd[8*int'(beat) +: 8];
      return {b, b};
    end
    return wd[16*int'(beat[0]) +: 16];
  endfunction

  // merge one returned memory word into the response accumulator
  function automatic logic [SYS_DW-1:0] merge_beat(logic [SYS_DW-1:0] acc, logic [MEM_DW-1:0] rd,
                                                   logic wide, logic [1:0] sz, logic a0,
                                                   logic [BEAT_W-1:0] beat);
    logic [SYS_DW-1:0] r;
    r = acc;
    if (!wide)            r[8*int'(beat) +: 8] = rd[7:0];
    else if (sz == 2'd0)  r[7:0] = a0 ? rd[15:8] : rd[7:0];
    else                  r[16*int'(beat[0]) +: 16] = rd;
    return r;
  endfunction

  // writes the target device cannot take
  function automatic logic is_rejected(logic wr, logic [1:0] sz, region_cfg_t c);
    return wr && (!c.wen || (c.wide && !c.bsel && sz == 2'd0));
  endfunction
endpackage

// File: rtl/xmem_region_decode.sv
module xmem_region_decode
  import xmem_pkg::*;
(
  input  logic              active,
  input  logic [CS_W-1:0]   sel,
  output logic [NUM_CS-1:0] cs_n
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = ~(active && (sel == CS_W'(g)));
  end
endmodule

// File: rtl/xmem_beat_ctrl.sv
module xmem_beat_ctrl
  import xmem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              reject,
  input  logic [BEAT_W:0]   n_beats,
  input  logic              mem_done,
  output logic              idle,
  output logic              mem_req,
  output logic              rsp_valid,
  output logic [BEAT_W-1:0] beat,
  output logic              beat_done,
  output logic              last_done
);
  xstate_e state;

  assign idle      = (state == ST_IDLE);
  assign mem_req   = (state == ST_BEAT);
  assign rsp_valid = (state == ST_RESP);
  assign beat_done = mem_req && mem_done;
  assign last_done = beat_done && ({1'b0, beat} == n_beats - (BEAT_W+1)'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      beat  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          beat  <= '0;
          state <= reject ? ST_RESP : ST_BEAT;
        end
        ST_BEAT: begin
          if (last_done)      state <= ST_RESP;
          else if (beat_done) beat  <= beat + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_BEAT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ({1'b0, beat} < n_beats)); // R3
  AST_DONE_ENDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    last_done |=> !mem_req && rsp_valid); // R8
endmodule

// File: rtl/xmem_read_gather.sv
module xmem_read_gather
  import xmem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              beat_done,
  input  logic [MEM_DW-1:0] rd,
  input  logic              wide,
  input  logic [1:0]        sz,
  input  logic              a0,
  input  logic [BEAT_W-1:0] beat,
  output logic [SYS_DW-1:0] acc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         acc <= '0;
    else if (clear)     acc <= '0;
    else if (beat_done) acc <= merge_beat(acc, rd, wide, sz, a0, beat);
  end
endmodule

// File: rtl/xmem_splitter.sv
module xmem_splitter
  import xmem_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic [27:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic [3:0]  cfg_wide,
  input  logic [3:0]  cfg_bsel,
  input  logic [3:0]  cfg_wen,
  output logic        rsp_valid,
  output logic        rsp_err,
  output logic [31:0] rsp_rdata,
  output logic        mem_req,
  output logic        mem_write,
  output logic [3:0]  mem_cs_n,
  output logic [25:0] mem_addr,
  output logic [1:0]  mem_be_n,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  input  logic        mem_done
);
  // request capture
  logic [ADDR_W-1:0] r_addr;
  logic              r_write;
  logic [1:0]        r_size;
  logic [SYS_DW-1:0] r_wdata;
  region_cfg_t       r_cfg;
  logic              r_err;

  // named internal events
  logic              accept;
  logic              reject_in;
  region_cfg_t       cfg_in;
  logic [CS_W-1:0]   sel_in;
  logic [BEAT_W-1:0] beat;
  logic              beat_done;
  logic              last_done;
  logic [BEAT_W:0]   n_beats;
  logic [SYS_DW-1:0] gathered;

  assign sel_in    = req_addr[ADDR_W-1 -: CS_W];
  assign cfg_in    = '{wide: cfg_wide[sel_in], bsel: cfg_bsel[sel_in], wen: cfg_wen[sel_in]};
  assign reject_in = is_rejected(req_write, req_size, cfg_in);
  assign accept    = req_valid && req_ready;
  assign n_beats   = beat_count(r_size, r_cfg.wide);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_addr  <= '0;
      r_write <= 1'b0;
      r_size  <= 2'd0;
      r_wdata <= '0;
      r_cfg   <= '0;
      r_err   <= 1'b0;
    end else if (accept) begin
      r_addr  <= req_addr;
      r_write <= req_write;
      r_size  <= req_size;
      r_wdata <= req_wdata;
      r_cfg   <= cfg_in;
      r_err   <= reject_in;
    end
  end

  xmem_beat_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .reject    (reject_in),
    .n_beats   (n_beats),
    .mem_done  (mem_done),
    .idle      (req_ready),
    .mem_req   (mem_req),
    .rsp_valid (rsp_valid),
    .beat      (beat),
    .beat_done (beat_done),
    .last_done (last_done)
  );

  xmem_region_decode u_dec (
    .active (mem_req),
    .sel    (r_addr[ADDR_W-1 -: CS_W]),
    .cs_n   (mem_cs_n)
  );

  xmem_read_gather u_gather (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .beat_done (beat_done && !r_write),
    .rd        (mem_rdata),
    .wide      (r_cfg.wide),
    .sz        (r_size),
    .a0        (r_addr[0]),
    .beat      (beat),
    .acc       (gathered)
  );

  assign mem_write = mem_req && r_write;
  assign mem_addr  = ext_addr(r_addr[EXT_AW-1:0], r_cfg.wide, beat);
  assign mem_be_n  = mem_req ? lane_en_n(r_write, r_cfg.wide, r_size, r_addr[0]) : 2'b11;
  assign mem_wdata = beat_wdata(r_wdata, r_cfg.wide, r_size, beat);
  assign rsp_err   = rsp_valid && r_err;
  assign rsp_rdata = (rsp_valid && !r_err && !r_write) ? gathered : '0;

  AST_CS_SINGLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $countones(~mem_cs_n) == 1); // R1
  AST_CS_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> mem_cs_n == 4'hF); // R1
  AST_READ_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_write) |-> mem_be_n == 2'b00); // R5
  AST_NOBSEL_FULL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_write && r_cfg.wide && !r_cfg.bsel) |-> mem_be_n == 2'b00); // R6
  AST_WRITE_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_write |-> r_cfg.wen); // R7
  AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_done) |=> mem_req && $stable(mem_addr) && $stable(mem_cs_n)
                               && $stable(mem_be_n) && $stable(mem_wdata)); // R9
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready); // R8
  AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && reject_in) |=> !mem_req && rsp_valid && rsp_err); // R6
endmodule

// File: tb/tb_xmem_splitter.sv
`timescale 1ns/1ps
module tb_xmem_splitter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [27:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  cfg_wide = '0, cfg_bsel = '0, cfg_wen = '0;
  logic        req_ready, rsp_valid, rsp_err, mem_req, mem_write;
  logic [31:0] rsp_rdata;
  logic [3:0]  mem_cs_n;
  logic [25:0] mem_addr;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_done = 1'b0;

  always #2.5 clk = ~clk;

  xmem_splitter dut (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  // recorded sub-accesses
  int          rec_n = 0;
  int          dly = 0;
  logic [25:0] rec_addr [0:7];
  logic [1:0]  rec_be   [0:7];
  logic [15:0] rec_wd   [0:7];
  logic [3:0]  rec_cs   [0:7];
  logic        rec_wr   [0:7];

  function automatic logic [15:0] mword(int cs, logic [25:0] a);
    return {a[7:0] ^ 8'hA5, a[7:0] + 8'(cs * 29)};
  endfunction

  function automatic int cs_idx(logic [3:0] c);
    for (int i = 0; i < 4; i++) if (!c[i]) return i;
    return 0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory-side timing engine model
  always @(negedge clk) begin
    if (mem_done) begin
      mem_done = 1'b0;
      dly = 0;
    end else if (mem_req) begin
      if (dly >= rec_n % 3) begin
        if (rec_n < 8) begin
          rec_addr[rec_n] = mem_addr;
          rec_be[rec_n]   = mem_be_n;
          rec_wd[rec_n]   = mem_wdata;
          rec_cs[rec_n]   = mem_cs_n;
          rec_wr[rec_n]   = mem_write;
        end
        mem_rdata = mword(cs_idx(mem_cs_n), mem_addr);
        rec_n++;
        mem_done = 1'b1;
      end else dly++;
    end
  end

  task automatic do_txn(input int rg, input logic wr, input logic [1:0] sz, input logic [25:0] off,
                        input logic [31:0] wd);
    bit wide, bsel, wen, rej;
    int nb, bytes;
    logic [31:0] er;
    logic [25:0] wa, ea;
    logic [15:0] w0, w1, ew;
    logic [1:0]  eb;
    logic [7:0]  b;
    wide = cfg_wide[rg]; bsel = cfg_bsel[rg]; wen = cfg_wen[rg];
    bytes = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    rej = wr && (!wen || (wide && !bsel && sz == 2'd0));
    nb = rej ? 0 : (wide ? ((bytes == 4) ? 2 : 1) : bytes);
    wa = {1'b0, off[25:1]};
    er = '0;
    if (!wr && !rej) begin
      if (wide) begin
        w0 = mword(rg, wa); w1 = mword(rg, wa + 26'd1);
        if (sz == 2'd0)      er = {24'd0, off[0] ? w0[15:8] : w0[7:0]};
        else if (sz == 2'd1) er = {16'd0, w0};
        else                 er = {w1, w0};
      end else begin
        for (int k = 0; k < bytes; k++) begin
          w0 = mword(rg, off + 26'(k));
          er[8*k +: 8] = w0[7:0];
        end
      end
    end
    while (!req_ready) @(negedge clk);
    rec_n = 0;
    req_valid = 1'b1; req_write = wr; req_size = sz;
    req_addr = {2'(rg), off}; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && !finished) @(negedge clk);
    check(rsp_err == rej, wr ? "R7 R6 error flag" : "R6 R7 read error flag", 32'(rsp_err), 32'(rej));
    check(rsp_rdata == er, "R5 response data", rsp_rdata, er);
    check(rec_n == nb, "R3 R8 sub-access count before completion", 32'(rec_n), 32'(nb));
    for (int k = 0; k < nb && k < rec_n; k++) begin
      ea = wide ? wa + 26'(k) : off + 26'(k);
      eb = !wr ? 2'b00 : (!wide ? 2'b10 : (sz == 2'd0 ? (off[0] ? 2'b01 : 2'b10) : 2'b00));
      if (wide && sz != 2'd0) ew = wd[16*k +: 16];
      else begin b = wd[8*k +: 8]; ew = {b, b}; end
      check(rec_addr[k] == ea, "R2 external address", 32'(rec_addr[k]), 32'(ea));
      check(rec_be[k] == eb, wr ? "R4 write lane enables" : "R5 read lane enables",
            32'(rec_be[k]), 32'(eb));
      check(rec_cs[k] == ~(4'b1 << rg), "R1 chip select", 32'(rec_cs[k]), 32'(~(4'b1 << rg)));
      check(rec_wr[k] == wr, "R9 direction", 32'(rec_wr[k]), 32'(wr));
      if (wr) check(rec_wd[k] == ew, "R4 write data lanes", 32'(rec_wd[k]), 32'(ew));
    end
    @(negedge clk);
    check(req_ready && !rsp_valid, "R8 single pulse then idle", {30'd0, req_ready, rsp_valid}, 32'h2);
  endtask

  initial begin
    logic [25:0] base;
    int t = 0;
    int ty;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R8 ready after reset", 32'(req_ready), 32'd1);
    check(!rsp_valid && !mem_req, "R8 quiet after reset", {30'd0, rsp_valid, mem_req}, 32'd0);
    check(mem_cs_n == 4'hF, "R1 selects high after reset", 32'(mem_cs_n), 32'hF);
    for (int p = 0; p < 4; p++) begin
      for (int r = 0; r < 4; r++) begin
        ty = (r + p) % 4;
        cfg_wide[r] = (ty != 0);
        cfg_bsel[r] = (ty != 2);
        cfg_wen[r]  = (ty != 3);
      end
      for (int bi = 0; bi < 2; bi++) begin
        base = (bi == 0) ? (26'h0123450 + 26'(p) * 26'h0100020) : 26'h3FFFFFC;
        for (int r = 0; r < 4; r++) begin
          for (int w = 0; w < 2; w++) begin
            for (int o = 0; o < 4; o++) begin
              t++;
              do_txn(r, w[0], 2'd0, base + 26'(o), 32'hC0DE_0000 ^ (32'(t) * 32'h9E37_79B1));
            end
            for (int o = 0; o < 4; o += 2) begin
              t++;
              do_txn(r, w[0], 2'd1, base + 26'(o), 32'h1234_0000 ^ (32'(t) * 32'h6A09_E667));
            end
            t++;
            do_txn(r, w[0], (t % 2 == 0) ? 2'd2 : 2'd3, base, 32'hBB67_AE85 ^ (32'(t) * 32'h3C6E_F372));
          end
        end
      end
    end
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R8 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule